// File: doc/BRIEF.md
# Two-Level Password Write Guard

This block sits between a register bus interface and a 256-byte register space. It decides whether a write is allowed at any given address, and whether a read at any given address returns real data. The rules come from a two-level password scheme. The block owns three 32-bit values:

- a volatile key-entry register;
- a stored level-1 key;
- a stored level-2 key.

The two stored keys are held in plain registers that stand in for nonvolatile storage.

The bus interface presents the target address of a pending write, together with its data and a request strobe. It also presents an independent read address. The block answers with two combinational grants. It applies granted writes to its own key bytes. Writes to any other address are carried out by the surrounding logic, using the grant.

The access level is found by comparing the entry register with each stored key:

- A match on the level-2 key grants level 2, and level 2 includes every right of level 1.
- Both stored keys reset to zero, as does the entry. After reset the entry therefore matches, and the register space is open until a stored key is changed.
- A key byte that is granted and written changes the level seen in the very next cycle.

Top module: `pwguard_top`

## Requirements
- R1: After reset the entry register and both stored keys are all zeros, so `lvl1_ok` and `lvl2_ok` are both 1.
- R2: The entry register is written one byte per address at 88h..8Bh, and 88h holds bits 31:24 (most significant byte first). The level-1 key sits at 90h..93h and the level-2 key at 94h..97h, with the same byte order.
- R3: `lvl2_ok` is 1 exactly when the entry equals the level-2 key. Whenever `lvl2_ok` is 1, `lvl1_ok` is also 1.
- R4: `lvl1_ok` is 1 when the entry equals the level-1 key, even if it does not equal the level-2 key.
- R5: `wr_grant` follows the address class:
  - 80h..87h needs level 1;
  - 00h..7Fh, 90h..97h and 98h..FFh need level 2;
  - 88h..8Eh is always granted;
  - 8Fh is never granted.
- R6: `rd_grant` is 0 for 88h..8Bh and 90h..97h, where the bus returns 00h. It is 1 for every other address.
- R7: A write that is requested but not granted leaves the entry and both stored keys unchanged.
- R8: The levels are derived combinationally from the stored bytes. A granted key-byte write changes `lvl1_ok`/`lvl2_ok` in the cycle after its clock edge, and the grant for that write uses the level that held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request strobe for the current cycle |
| wr_addr | input | 8 | Address of the pending write |
| wr_data | input | 8 | Data of the pending write |
| rd_addr | input | 8 | Address of the current read |
| wr_grant | output | 1 | Write at `wr_addr` is permitted now |
| rd_grant | output | 1 | Read at `rd_addr` returns data (0 means 00h) |
| lvl1_ok | output | 1 | Level-1 rights are held |
| lvl2_ok | output | 1 | Level-2 rights are held |

## Verification
A write to a level-2 key byte is both gated by the current level and able to destroy that level. The grant and the level change therefore meet on the same clock edge.

The bench provokes this collision by rewriting the level-2 key one byte at a time. At each step it expects:

1. the granted byte write drops `lvl2_ok` in the next cycle;
2. a further key write attempted while the level is lost is refused and changes nothing;
3. re-entering the matching entry byte restores the level.

Full 256-address sweeps of both grants are then judged against an arithmetic address-class rule at no access, at level 1 and at level 2.

// File: rtl/pwguard_pkg.sv
package pwguard_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int KEY_BYTES = 4;
    localparam int KEY_W     = DATA_W * KEY_BYTES;

    localparam logic [ADDR_W-1:0] ENTRY_BASE  = 8'h88;
    localparam logic [ADDR_W-1:0] KEY1_BASE   = 8'h90;
    localparam logic [ADDR_W-1:0] KEY2_BASE   = 8'h94;
    localparam logic [ADDR_W-1:0] L1_LO       = 8'h80;
    localparam logic [ADDR_W-1:0] L1_HI       = 8'h87;
    localparam logic [ADDR_W-1:0] SCRATCH_LO  = 8'h8C;
    localparam logic [ADDR_W-1:0] SCRATCH_HI  = 8'h8E;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h8F;

    typedef enum logic [1:0] {
        RULE_OPEN = 2'd0,
        RULE_L1   = 2'd1,
        RULE_L2   = 2'd2,
        RULE_LOCK = 2'd3
    } wr_rule_e;

    typedef struct packed {
        wr_rule_e rule;
        logic     rd_ok;
    } addr_rights_t;

    typedef struct packed {
        logic lvl1;
        logic lvl2;
    } grant_lvl_t;

    function automatic logic in_key(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] base);
        return (int'(addr) >= int'(base)) && (int'(addr) < int'(base) + KEY_BYTES);
    endfunction

    function automatic addr_rights_t classify(input logic [ADDR_W-1:0] addr);
        addr_rights_t r;
        r.rd_ok = 1'b1;
        r.rule  = RULE_L2;
        if (in_key(addr, ENTRY_BASE)) begin
            r.rule  = RULE_OPEN;
            r.rd_ok = 1'b0;
        end else if (in_key(addr, KEY1_BASE) || in_key(addr, KEY2_BASE)) begin
            r.rule  = RULE_L2;
            r.rd_ok = 1'b0;
        end else if (addr >= L1_LO && addr <= L1_HI) begin
            r.rule = RULE_L1;
        end else if (addr >= SCRATCH_LO && addr <= SCRATCH_HI) begin
            r.rule = RULE_OPEN;
        end else if (addr == STATUS_ADDR) begin
            r.rule = RULE_LOCK;
        end
        return r;
    endfunction

endpackage

// File: rtl/pwguard_keystore.sv
module pwguard_keystore
    import pwguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [KEY_W-1:0]  entry_key,
    output logic [KEY_W-1:0]  key1,
    output logic [KEY_W-1:0]  key2
);

    for (genvar i = 0; i < KEY_BYTES; i++) begin : g_byte
        localparam int HI = KEY_W - 1 - DATA_W * i;

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_key[HI -: DATA_W] <= '0;
                key1[HI -: DATA_W]      <= '0;
                key2[HI -: DATA_W]      <= '0;
            end else if (wr_en) begin
                if (wr_addr == ENTRY_BASE + ADDR_W'(i))
                    entry_key[HI -: DATA_W] <= wr_data;
                if (wr_addr == KEY1_BASE + ADDR_W'(i))
                    key1[HI -: DATA_W] <= wr_data;
                if (wr_addr == KEY2_BASE + ADDR_W'(i))
                    key2[HI -: DATA_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pwguard_match.sv
module pwguard_match
    import pwguard_pkg::*;
(
    input  logic [KEY_W-1:0] entry_key,
    input  logic [KEY_W-1:0] key1,
    input  logic [KEY_W-1:0] key2,
    output grant_lvl_t       lvl
);

    logic hit1;
    logic hit2;

    always_comb begin
        hit1     = (entry_key == key1);
        hit2     = (entry_key == key2);
        lvl.lvl2 = hit2;
        lvl.lvl1 = hit1 | hit2;
    end

endmodule

// File: rtl/pwguard_policy.sv
module pwguard_policy
    import pwguard_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  grant_lvl_t        lvl,
    output logic              wr_grant,
    output logic              rd_grant
);

    addr_rights_t wr_rights;
    addr_rights_t rd_rights;

    always_comb begin
        wr_rights = classify(wr_addr);
        rd_rights = classify(rd_addr);
        unique case (wr_rights.rule)
            RULE_OPEN: wr_grant = 1'b1;
            RULE_L1:   wr_grant = lvl.lvl1;
            RULE_L2:   wr_grant = lvl.lvl2;
            default:   wr_grant = 1'b0;
        endcase
        rd_grant = rd_rights.rd_ok;
    end

endmodule

// File: rtl/pwguard_top.sv
module pwguard_top
    import pwguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              wr_grant,
    output logic              rd_grant,
    output logic              lvl1_ok,
    output logic              lvl2_ok
);

    logic [KEY_W-1:0] entry_key;
    logic [KEY_W-1:0] key1;
    logic [KEY_W-1:0] key2;
    grant_lvl_t       lvl;
    logic             store_en;

    assign store_en = wr_req & wr_grant;

    pwguard_keystore u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (store_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .entry_key (entry_key),
        .key1      (key1),
        .key2      (key2)
    );

    pwguard_match u_match (
        .entry_key (entry_key),
        .key1      (key1),
        .key2      (key2),
        .lvl       (lvl)
    );

    pwguard_policy u_policy (
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .lvl      (lvl),
        .wr_grant (wr_grant),
        .rd_grant (rd_grant)
    );

    assign lvl1_ok = lvl.lvl1;
    assign lvl2_ok = lvl.lvl2;

    AST_RESET_OPEN: assert property (@(posedge clk) $fell(rst) |-> (lvl1_ok && lvl2_ok)); // R1
    AST_L2_IMPLIES_L1: assert property (@(posedge clk) disable iff (rst) lvl2_ok |-> lvl1_ok); // R3
    AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (rst) (wr_addr == STATUS_ADDR) |-> !wr_grant); // R5
    AST_L1_AREA_NEEDS_LVL: assert property (@(posedge clk) disable iff (rst) (wr_addr >= L1_LO && wr_addr <= L1_HI && wr_grant) |-> lvl1_ok); // R5
    AST_ENTRY_HIDDEN: assert property (@(posedge clk) disable iff (rst) (rd_addr >= ENTRY_BASE && rd_addr < ENTRY_BASE + 8'd4) |-> !rd_grant); // R6
    AST_DENIED_NO_CHANGE: assert property (@(posedge clk) disable iff (rst) (wr_req && !wr_grant) |=> ($stable(lvl1_ok) && $stable(lvl2_ok))); // R7
    AST_IDLE_LEVEL_STABLE: assert property (@(posedge clk) disable iff (rst) (!wr_req && !$past(rst)) |=> ($stable(lvl1_ok) && $stable(lvl2_ok))); // R8

endmodule

// File: tb/pwguard_top_tb_top.sv
module pwguard_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_req = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic       wr_grant, rd_grant, lvl1_ok, lvl2_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwguard_top dut_i (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .wr_grant(wr_grant),
        .rd_grant(rd_grant), .lvl1_ok(lvl1_ok), .lvl2_ok(lvl2_ok)
    );

    task automatic check(input string req, input logic act, input logic exp, input int addr);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%02h actual=%b expected=%b", req, addr, act, exp);
        end
    endtask

    function automatic logic exp_wr(input int a, input logic l1, input logic l2);
        if (a < 'h80) return l2;
        if (a <= 'h87) return l1;
        if (a <= 'h8E) return 1'b1;
        if (a == 'h8F) return 1'b0;
        return l2;
    endfunction

    function automatic logic exp_rd(input int a);
        return !((a >= 'h88 && a <= 'h8B) || (a >= 'h90 && a <= 'h97));
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_req  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic sweep(input logic l1, input logic l2, input string tag);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            wr_addr = 8'(a);
            rd_addr = 8'(a);
            #1;
            check({"R5 ", tag}, wr_grant, exp_wr(a, l1, l2), a);
            check("R6", rd_grant, exp_rd(a), a);
        end
    endtask

    task automatic lvl_chk(input string req, input logic e1, input logic e2);
        #1;
        check(req, lvl1_ok, e1, 1);
        check(req, lvl2_ok, e2, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        lvl_chk("R1 reset", 1'b1, 1'b1);
        sweep(1'b1, 1'b1, "open");

        // level-1 key = 11223344 written under level 2 (entry 0 = key2 0)
        wr(8'h90, 8'h11); wr(8'h91, 8'h22); wr(8'h92, 8'h33); wr(8'h93, 8'h44);
        lvl_chk("R3 key1 change keeps lvl2", 1'b1, 1'b1);

        // level-2 key byte write drops level next cycle (R8)
        wr(8'h94, 8'hA1);
        lvl_chk("R8 lvl2 drop after key2 byte", 1'b0, 1'b0);
        // denied write leaves key2 unchanged (R7)
        wr(8'h95, 8'hFF);
        lvl_chk("R7 denied write", 1'b0, 1'b0);
        wr(8'h88, 8'hA1);  // entry A1000000 MSB first (R2)
        lvl_chk("R2 MSB-first entry / R7 key2 intact", 1'b1, 1'b1);
        wr(8'h95, 8'hB2);
        lvl_chk("R8 drop byte2", 1'b0, 1'b0);
        wr(8'h89, 8'hB2);
        lvl_chk("R3 regain byte2", 1'b1, 1'b1);
        wr(8'h96, 8'hC3); wr(8'h8A, 8'hC3);
        wr(8'h97, 8'hD4);
        lvl_chk("R8 drop byte4", 1'b0, 1'b0);
        wr(8'h8B, 8'hD4);
        lvl_chk("R3 full key2", 1'b1, 1'b1);
        sweep(1'b1, 1'b1, "lvl2");

        // entry = level-1 key -> level 1 only (R4)
        wr(8'h88, 8'h11); wr(8'h89, 8'h22); wr(8'h8A, 8'h33); wr(8'h8B, 8'h44);
        lvl_chk("R4 level1 only", 1'b1, 1'b0);
        wr(8'h94, 8'h00);  // denied at level 1
        wr(8'h8B, 8'h00);
        wr(8'h8A, 8'h00);
        wr(8'h89, 8'h00);
        wr(8'h88, 8'h00);
        lvl_chk("R7 key2 not cleared by level1", 1'b0, 1'b0);
        wr(8'h88, 8'h11); wr(8'h89, 8'h22); wr(8'h8A, 8'h33); wr(8'h8B, 8'h44);
        sweep(1'b1, 1'b0, "lvl1");

        // byte order: reversed bytes do not match (R2)
        wr(8'h88, 8'h44); wr(8'h8B, 8'h11);
        lvl_chk("R2 reversed order", 1'b0, 1'b0);
        sweep(1'b0, 1'b0, "none");

        // denied write to 8Fh and 9Fh keep levels (R7)
        wr(8'h8F, 8'h55); wr(8'h9F, 8'h55);
        lvl_chk("R7 locked writes", 1'b0, 1'b0);

        // reset restores open state (R1)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        lvl_chk("R1 re-reset", 1'b1, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule